// File: doc/BRIEF.md
# Protected Memory Range DMA Filter

This block screens memory requests issued by bus masters (DMA) against two programmable protected windows. Secure code and private data sit inside these windows, and devices must not reach them. One window, the low window, lies wholly below the 4 GB line. The other, the high window, has a variable size and lies wholly at or above that line. Because of this split the two windows can never overlap. Window bounds are kept with 1 MB granularity. Each window is armed on its own through a control register. Arming does not depend on any address-remapping engine, so protection can be switched on before such an engine exists or runs.

Requests enter on a valid/ready stream. Each accepted request yields exactly one verdict on a valid/ready output stream, registered one clock after acceptance. A new request is accepted only when the verdict slot is empty or is being drained in the same cycle: `req_ready = !vrd_valid || vrd_ready`. While `vrd_valid` is high and `vrd_ready` is low, the verdict and its flags are held. A blocked read is marked so that the fabric returns all-ones data. A blocked write is marked for dropping. Each block also advances a saturating violation counter.

Top module: `prf_filter`

## Requirements
- R1: After reset, `vrd_valid`, `cfg_err` and `viol_cnt` are 0, both windows are disarmed, and any request is allowed.
- R2: A request is blocked if and only if some byte of [addr, addr+len_m1] lies inside an armed window. Window bounds are written with `cfg_sel` 0 (low base) and 1 (low last-MB), taking `cfg_wdata[63:20]`. The window spans {base,20'h00000} to {last,20'hFFFFF}. A disarmed window never blocks.
- R3: A request that crosses either edge of an armed window by even one byte is blocked. A request that ends on the byte just before the window is allowed.
- R4: The high window is programmed with `cfg_sel` 2 (base) and 3 (last-MB). It blocks in the same way as the low window.
- R5: A control write (`cfg_sel` 4, bit0 arms low, bit1 arms high) that tries to arm the low window with its last MB at or above 4 GB, or the high window with its base below 4 GB, leaves that window disarmed and sets `cfg_err`. Once set, `cfg_err` stays high until reset.
- R6: Writes to a window's base or last-MB register are ignored while that window is armed.
- R7: Control bit2 locks the configuration. After the lock, writes to control and to bound registers are ignored until reset.
- R8: The verdict appears with `vrd_valid` on the clock after `req_valid && req_ready`. It is held stable while `vrd_ready` is low, and `req_ready` is low during that time.
- R9: For a blocked read, `vrd_fill_ones` is set. For a blocked write, `vrd_drop` is set. Neither is set when the request is allowed.
- R10: `viol_cnt` rises by one for each blocked request and saturates at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 low base, 1 low last, 2 high base, 3 high last, 4 control |
| cfg_wdata | input | 64 | Write data (bounds in [63:20], control in [2:0]) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | 64 | First byte address of the request |
| req_len_m1 | input | 16 | Request length in bytes minus one |
| req_write | input | 1 | 1 for write, 0 for read |
| vrd_valid | output | 1 | Verdict valid |
| vrd_ready | input | 1 | Verdict consumer ready |
| vrd_block | output | 1 | Request hits an armed window |
| vrd_fill_ones | output | 1 | Blocked read: return all-ones data |
| vrd_drop | output | 1 | Blocked write: discard |
| cfg_err | output | 1 | Sticky placement-error flag |
| viol_cnt | output | 8 | Saturating count of blocked requests |

## Verification
The assertions assume that reset is asserted for at least one clock before traffic begins. They also assume that `req_valid`, once raised, is only lowered after an accepting edge, so the handshake matches the stream rules above. The bench drives every input on the falling clock edge. It raises `req_valid` for exactly one accepting cycle, and it only drops `vrd_ready` when it tests back-pressure. The configuration port is exercised only through single-cycle writes. None of these writes coincides with a request.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int unsigned MB_SHIFT = 20;
  localparam int unsigned LINE_4G  = 32;

  typedef enum logic [2:0] {
    SEL_LO_BASE = 3'd0,
    SEL_LO_LAST = 3'd1,
    SEL_HI_BASE = 3'd2,
    SEL_HI_LAST = 3'd3,
    SEL_CTRL    = 3'd4
  } cfg_sel_e;

  localparam int unsigned CTRL_LO_ARM = 0;
  localparam int unsigned CTRL_HI_ARM = 1;
  localparam int unsigned CTRL_LOCK   = 2;
endpackage

// File: rtl/prf_regs.sv
module prf_regs
  import prf_pkg::*;
#(
  parameter int unsigned IDX_W = 44
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       sel,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [2:0]       wr_ctrl,
  output logic [1:0]       arm,
  output logic [1:0][IDX_W-1:0] base,
  output logic [1:0][IDX_W-1:0] last,
  output logic             err
);
  localparam logic [IDX_W-1:0] LINE_IDX = IDX_W'(64'd1 << (LINE_4G - MB_SHIFT));

  logic locked;
  logic lo_ok, hi_ok;

  // Placement rules checked at the moment of arming
  assign lo_ok = (last[0] < LINE_IDX) && (base[0] <= last[0]);
  assign hi_ok = (base[1] >= LINE_IDX) && (base[1] <= last[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm    <= '0;
      base   <= '0;
      last   <= '0;
      locked <= 1'b0;
      err    <= 1'b0;
    end else if (we && !locked) begin
      case (cfg_sel_e'(sel))
        SEL_LO_BASE: if (!arm[0]) base[0] <= wr_idx;
        SEL_LO_LAST: if (!arm[0]) last[0] <= wr_idx;
        SEL_HI_BASE: if (!arm[1]) base[1] <= wr_idx;
        SEL_HI_LAST: if (!arm[1]) last[1] <= wr_idx;
        SEL_CTRL: begin
          arm[0] <= wr_ctrl[CTRL_LO_ARM] && lo_ok;
          arm[1] <= wr_ctrl[CTRL_HI_ARM] && hi_ok;
          locked <= wr_ctrl[CTRL_LOCK];
          if ((wr_ctrl[CTRL_LO_ARM] && !lo_ok) || (wr_ctrl[CTRL_HI_ARM] && !hi_ok))
            err <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/prf_window.sv
module prf_window
  import prf_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned IDX_W = AW - MB_SHIFT
) (
  input  logic             armed,
  input  logic [IDX_W-1:0] base,
  input  logic [IDX_W-1:0] last,
  input  logic [AW-1:0]    first_b,
  input  logic [AW-1:0]    last_b,
  output logic             hit
);
  logic [AW-1:0] win_lo, win_hi;
  assign win_lo = {base, {MB_SHIFT{1'b0}}};
  assign win_hi = {last, {MB_SHIFT{1'b1}}};
  assign hit = armed && (base <= last) && (first_b <= win_hi) && (last_b >= win_lo);
endmodule

// File: rtl/prf_viol_cnt.sv
module prf_viol_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (inc && !(&cnt))   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/prf_filter.sv
module prf_filter
  import prf_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len_m1,
  input  logic             req_write,
  output logic             vrd_valid,
  input  logic             vrd_ready,
  output logic             vrd_block,
  output logic             vrd_fill_ones,
  output logic             vrd_drop,
  output logic             cfg_err,
  output logic [CNT_W-1:0] viol_cnt
);
  localparam int unsigned IDX_W = AW - MB_SHIFT;
  localparam int unsigned NWIN  = 2;

  logic [NWIN-1:0]            arm;
  logic [NWIN-1:0][IDX_W-1:0] base, last;
  logic [NWIN-1:0]            win_hit;
  logic                       unused_wdata;
  logic [AW:0]                end_sum;
  logic [AW-1:0]              last_byte;
  logic                       accept, hit;

  assign unused_wdata = ^cfg_wdata[MB_SHIFT-1:3];

  prf_regs #(.IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
    .wr_idx(cfg_wdata[AW-1:MB_SHIFT]), .wr_ctrl(cfg_wdata[2:0]),
    .arm(arm), .base(base), .last(last), .err(cfg_err)
  );

  // End address saturates at the top of the space instead of wrapping
  assign end_sum   = {1'b0, req_addr} + (AW+1)'(req_len_m1);
  assign last_byte = end_sum[AW] ? '1 : end_sum[AW-1:0];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    prf_window #(.AW(AW), .IDX_W(IDX_W)) u_win (
      .armed(arm[g]), .base(base[g]), .last(last[g]),
      .first_b(req_addr), .last_b(last_byte), .hit(win_hit[g])
    );
  end

  assign hit       = |win_hit;
  assign req_ready = !vrd_valid || vrd_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vrd_valid     <= 1'b0;
      vrd_block     <= 1'b0;
      vrd_fill_ones <= 1'b0;
      vrd_drop      <= 1'b0;
    end else if (accept) begin
      vrd_valid     <= 1'b1;
      vrd_block     <= hit;
      vrd_fill_ones <= hit && !req_write;
      vrd_drop      <= hit && req_write;
    end else if (vrd_ready) begin
      vrd_valid     <= 1'b0;
    end
  end

  prf_viol_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(accept && hit), .cnt(viol_cnt)
  );
endmodule

// File: rtl/prf_filter_chk.sv
module prf_filter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             vrd_valid,
  input logic             vrd_ready,
  input logic             vrd_block,
  input logic             vrd_fill_ones,
  input logic             vrd_drop,
  input logic             cfg_err,
  input logic [CNT_W-1:0] viol_cnt
);
  a_r8_verdict_next: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> vrd_valid);

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid && !vrd_ready |=> vrd_valid && $stable(vrd_block) && $stable(vrd_drop)
      && $stable(vrd_fill_ones));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid && !vrd_ready |-> !req_ready);

  a_r9_kind: assert property (@(posedge clk) disable iff (!rst_n)
    vrd_valid |-> ((vrd_fill_ones || vrd_drop) == vrd_block) && !(vrd_fill_ones && vrd_drop));

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (&viol_cnt) |=> (&viol_cnt));

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (viol_cnt == $past(viol_cnt)) || (viol_cnt == $past(viol_cnt) + 1'b1));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
endmodule

bind prf_filter prf_filter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .vrd_valid(vrd_valid), .vrd_ready(vrd_ready), .vrd_block(vrd_block),
  .vrd_fill_ones(vrd_fill_ones), .vrd_drop(vrd_drop), .cfg_err(cfg_err),
  .viol_cnt(viol_cnt)
);

// File: tb/prf_filter_test.sv
`timescale 1ns/1ps
module prf_filter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [15:0] req_len_m1 = '0;
  logic        req_write = 1'b0;
  logic        vrd_valid;
  logic        vrd_ready = 1'b1;
  logic        vrd_block, vrd_fill_ones, vrd_drop, cfg_err;
  logic [7:0]  viol_cnt;

  int checks = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prf_filter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len_m1(req_len_m1), .req_write(req_write), .vrd_valid(vrd_valid),
    .vrd_ready(vrd_ready), .vrd_block(vrd_block), .vrd_fill_ones(vrd_fill_ones),
    .vrd_drop(vrd_drop), .cfg_err(cfg_err), .viol_cnt(viol_cnt)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  // One request, verdict checked one clock after acceptance
  task automatic send(input logic [63:0] addr, input logic [15:0] lm1, input logic wr,
                      input logic exp_blk, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_len_m1 = lm1; req_write = wr;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (exp_blk && exp_cnt < 255) exp_cnt++;
    check(req, {63'd0, vrd_valid}, 64'd1);
    check(req, {63'd0, vrd_block}, {63'd0, exp_blk});
    check("R9", {62'd0, vrd_fill_ones, vrd_drop}, {62'd0, exp_blk && !wr, exp_blk && wr});
  endtask

  task automatic t_reset();
    check("R1", {62'd0, vrd_valid, cfg_err}, 64'd0);
    check("R1", {56'd0, viol_cnt}, 64'd0);
    send(64'h1800_0000, 16'd0, 1'b0, 1'b0, "R1");
  endtask

  task automatic t_low();
    wr_cfg(3'd0, 64'h1000_0000);
    wr_cfg(3'd1, 64'h1FF0_0000);
    send(64'h1800_0000, 16'd0, 1'b0, 1'b0, "R2 disarmed");
    wr_cfg(3'd4, 64'h1);
    send(64'h1800_0000, 16'd63, 1'b0, 1'b1, "R2 inside");
    send(64'h2000_0000, 16'd0, 1'b1, 1'b0, "R2 outside");
    send(64'h0FFF_FFF0, 16'h1F, 1'b0, 1'b1, "R3 lower straddle");
    send(64'h0FFF_FFF0, 16'h0F, 1'b0, 1'b0, "R3 just below");
    send(64'h1FFF_FFFF, 16'd0, 1'b1, 1'b1, "R3 top byte");
    send(64'h1FFF_FFF8, 16'h10, 1'b0, 1'b1, "R3 upper straddle");
    check("R10", {56'd0, viol_cnt}, 64'(exp_cnt));
  endtask

  task automatic t_ignore_armed();
    wr_cfg(3'd0, 64'h3000_0000);
    send(64'h1800_0000, 16'd0, 1'b0, 1'b1, "R6 old window kept");
    send(64'h3000_0000, 16'd0, 1'b0, 1'b0, "R6 new base ignored");
  endtask

  task automatic t_high();
    wr_cfg(3'd2, 64'h1_0000_0000);
    wr_cfg(3'd3, 64'h1_00F0_0000);
    wr_cfg(3'd4, 64'h3);
    send(64'h1_0000_8000, 16'd7, 1'b1, 1'b1, "R4 inside");
    send(64'h1_0100_0000, 16'd0, 1'b1, 1'b0, "R4 above");
    send(64'h0FFF_FFFF_FFF0, 16'd0, 1'b0, 1'b0, "R4 far above");
    check("R5 no error yet", {63'd0, cfg_err}, 64'd0);
  endtask

  task automatic t_placement();
    wr_cfg(3'd4, 64'h0);
    wr_cfg(3'd1, 64'h1_0000_0000);
    wr_cfg(3'd4, 64'h1);
    check("R5 low error", {63'd0, cfg_err}, 64'd1);
    send(64'h1800_0000, 16'd0, 1'b0, 1'b0, "R5 low stays disarmed");
    wr_cfg(3'd2, 64'hFFF0_0000);
    wr_cfg(3'd4, 64'h2);
    send(64'hFFF0_0000, 16'd0, 1'b0, 1'b0, "R5 high stays disarmed");
    check("R5 error sticky", {63'd0, cfg_err}, 64'd1);
  endtask

  task automatic t_backpressure();
    wr_cfg(3'd1, 64'h1FF0_0000);
    wr_cfg(3'd4, 64'h1);
    @(negedge clk);
    vrd_ready = 1'b0;
    req_valid = 1'b1; req_addr = 64'h1100_0000; req_len_m1 = '0; req_write = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (exp_cnt < 255) exp_cnt++;
    check("R8 valid", {63'd0, vrd_valid}, 64'd1);
    check("R8 stall", {63'd0, req_ready}, 64'd0);
    @(posedge clk); #1;
    check("R8 held", {61'd0, vrd_valid, vrd_block, vrd_drop}, 64'h7);
    @(negedge clk);
    vrd_ready = 1'b1;
    @(posedge clk); #1;
    check("R8 drained", {63'd0, vrd_valid}, 64'd0);
  endtask

  task automatic t_lock();
    wr_cfg(3'd4, 64'h5);
    wr_cfg(3'd4, 64'h0);
    send(64'h1200_0000, 16'd0, 1'b0, 1'b1, "R7 ctrl locked");
    wr_cfg(3'd2, 64'h2_0000_0000);
    wr_cfg(3'd3, 64'h2_0000_0000);
    wr_cfg(3'd4, 64'h2);
    send(64'h2_0000_0000, 16'd0, 1'b0, 1'b0, "R7 high not armed");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 260; i++) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h1400_0000; req_len_m1 = '0; req_write = 1'b0;
      @(posedge clk); #1;
      req_valid = 1'b0;
      if (exp_cnt < 255) exp_cnt++;
    end
    @(negedge clk);
    check("R10 saturated", {56'd0, viol_cnt}, 64'd255);
    check("R10 model", 64'(exp_cnt), 64'd255);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_low();
    t_ignore_armed();
    t_high();
    t_placement();
    t_backpressure();
    t_lock();
    t_saturate();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule